// File: doc/BRIEF.md
# Interrupt Entry Stack Sequencer

This block carries out the context save and redirect that a small 8/16-bit processor core performs once it has accepted an interrupt or a software trap. On a one-cycle `start` pulse it captures the cause code, the current program counter, the bank register, the status byte, the stack pointer and the mode bit. It then pushes the return frame byte by byte onto a descending stack through a simple byte-wide memory port. It fetches the two-byte handler address from a vector chosen by the cause and the mode, and it presents the new program counter, bank, status and stack pointer with a one-cycle `done` pulse.

The core keeps ownership of instruction fetch, decode, return-from-interrupt and every other register. The accumulator and index registers are never saved here; handler code has to save them. The memory port is synchronous and has no wait states. Read data for an address on `mem_addr` is sampled at the clock edge that ends the read cycle.

The state machine has these states: IDLE, INIT, PUSH_BANK, PUSH_PCH, PUSH_PCL, PUSH_STAT, VEC_LO, VEC_HI and DONE. It moves through them as follows:
- IDLE goes to INIT when the cause is reset.
- IDLE goes to PUSH_BANK for any other cause in native mode.
- IDLE goes to PUSH_PCH for any other cause in emulation mode.
- INIT stays in INIT until its cycle count is used up, then goes to VEC_LO.
- Each push state goes to the next one in order: PUSH_BANK, PUSH_PCH, PUSH_PCL, PUSH_STAT.
- PUSH_STAT goes to VEC_LO.
- VEC_LO goes to VEC_HI.
- VEC_HI goes to DONE.
- DONE goes to IDLE.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low and `pc_out` is zero. A `start` is accepted only in IDLE. A `start` while busy, and any input change after acceptance, leave the running sequence and its results unchanged.
- R2: In native mode (`native`=1), four writes occur on consecutive cycles. The order is bank, saved PC high byte, saved PC low byte, then status. They go to addresses SP, SP-1, SP-2 and SP-3 with the full 16-bit pointer and address bits 23:16 zero. `sp_out` ends at SP-4.
- R3: In emulation mode, the bank is not pushed. Three writes (PC high, PC low, status) go to page 0x01. The pointer's low byte decrements and wraps within that page, and `sp_out` has high byte 0x01.
- R4: The saved PC is the captured PC plus two (modulo 2^16) for BRK (cause 2) and COP (cause 3). For IRQ (0), NMI (1) and ABORT (4, where the captured PC is the aborted instruction's address), the saved PC is the captured PC.
- R5: In emulation mode, the pushed status has bit 4 set for BRK and cleared for every other cause. In native mode, the pushed status equals the captured status.
- R6: The final `status_out` is the captured status with bit 2 (interrupt disable) set. Bit 3 (decimal) is cleared when `clr_decimal`=1 and kept when it is 0. All other bits are unchanged.
- R7: `bank_out` is 0x00 after a native-mode entry or a reset. It equals the captured bank after an emulation-mode entry.
- R8: Emulation vectors are FFF8 for ABORT, FFF4 for COP, FFFA for NMI, FFFC for reset (cause 5) and FFFE for both IRQ and BRK.
- R9: Native vectors are FFE8 for ABORT, FFE4 for COP, FFE6 for BRK, FFEA for NMI and FFEE for IRQ.
- R10: The vector is read with two reads in bank 0x00: the low byte at the even address, then the high byte at the next address one cycle later. `pc_out` = {high, low}.
- R11: A reset sequence issues no memory request for its first six cycles and makes no write at all. It reads FFFC/FFFD in either mode and leaves the stack pointer at the captured value (page-forced in emulation).
- R12: `done` pulses for one cycle, and `busy` is low in the next cycle. Counted in clock edges from the accepting edge, `done` appears 7 edges later in native mode, 6 in emulation mode and 9 for reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept request (IDLE only) |
| cause | input | 3 | 0 IRQ, 1 NMI, 2 BRK, 3 COP, 4 ABORT, 5 reset |
| native | input | 1 | 1 = native mode, 0 = emulation mode |
| clr_decimal | input | 1 | 1 = clear decimal flag on entry |
| pc_in | input | 16 | Current program counter / aborted instruction address |
| bank_in | input | 8 | Current program bank |
| status_in | input | 8 | Current status byte |
| sp_in | input | 16 | Current stack pointer |
| mem_rdata | input | 8 | Read data for the current read cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Memory address (bank:offset) |
| mem_wdata | output | 8 | Write data |
| pc_out | output | 16 | Handler address |
| bank_out | output | 8 | New program bank |
| status_out | output | 8 | New status byte |
| sp_out | output | 16 | Stack pointer after the pushes |

## Verification
The bench builds the block with its default parameters: a six-cycle initialization period and stack page 0x01. With a period that short, the reset path's vector fetch and its timing window are reached within a few cycles of each case. With page 0x01, emulation pushes that start at the bottom of the page wrap back to 0x01FF where the bench can observe them. The vector table covers every cause in both modes. It includes a native pointer that crosses zero and a COP at PC 0xFFFF, whose plus-two wraps.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    localparam int DATA_W = 8;
    localparam int PC_W   = 16;
    localparam int BANK_W = 8;
    localparam int ADDR_W = BANK_W + PC_W;

    localparam int FLAG_I = 2;
    localparam int FLAG_D = 3;
    localparam int FLAG_B = 4;

    typedef enum logic [2:0] {
        C_IRQ   = 3'd0,
        C_NMI   = 3'd1,
        C_BRK   = 3'd2,
        C_COP   = 3'd3,
        C_ABORT = 3'd4,
        C_RESET = 3'd5
    } cause_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_INIT,
        S_PUSH_BANK,
        S_PUSH_PCH,
        S_PUSH_PCL,
        S_PUSH_STAT,
        S_VEC_LO,
        S_VEC_HI,
        S_DONE
    } state_e;

endpackage

// File: rtl/intr_vec_map.sv
module intr_vec_map
    import intr_seq_pkg::*;
#(
    parameter int AW = PC_W
) (
    input  cause_e          cause,
    input  logic            native,
    output logic [AW-1:0]   vec
);

    always_comb begin
        vec = AW'(16'hFFFE);
        if (cause == C_RESET) begin
            // reset always goes through the emulation vector
            vec = AW'(16'hFFFC);
        end else if (native) begin
            unique case (cause)
                C_ABORT: vec = AW'(16'hFFE8);
                C_COP:   vec = AW'(16'hFFE4);
                C_BRK:   vec = AW'(16'hFFE6);
                C_NMI:   vec = AW'(16'hFFEA);
                default: vec = AW'(16'hFFEE);
            endcase
        end else begin
            unique case (cause)
                C_ABORT: vec = AW'(16'hFFF8);
                C_COP:   vec = AW'(16'hFFF4);
                C_NMI:   vec = AW'(16'hFFFA);
                default: vec = AW'(16'hFFFE);
            endcase
        end
    end

endmodule

// File: rtl/intr_frame_build.sv
module intr_frame_build
    import intr_seq_pkg::*;
(
    input  cause_e              cause,
    input  logic                native,
    input  logic                clr_dec,
    input  logic [PC_W-1:0]     pc,
    input  logic [DATA_W-1:0]   status,
    output logic [PC_W-1:0]     ret_pc,
    output logic [DATA_W-1:0]   push_stat,
    output logic [DATA_W-1:0]   entry_stat
);

    logic skip_sig;

    always_comb begin
        skip_sig = (cause == C_BRK) || (cause == C_COP);
        ret_pc   = skip_sig ? pc + PC_W'(2) : pc;

        push_stat = status;
        if (!native) begin
            push_stat[FLAG_B] = (cause == C_BRK);
        end

        entry_stat         = status;
        entry_stat[FLAG_I] = 1'b1;
        if (clr_dec) begin
            entry_stat[FLAG_D] = 1'b0;
        end
    end

endmodule

// File: rtl/intr_stack_ptr.sv
module intr_stack_ptr #(
    parameter int          AW     = 16,
    parameter int          PAGE_W = 8,
    parameter logic [7:0]  PAGE   = 8'h01
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [AW-1:0]   load_val,
    input  logic            native,
    input  logic            dec,
    output logic [AW-1:0]   sp
);

    localparam int LO_W = AW - PAGE_W;

    logic [AW-1:0] sp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (load) begin
            sp_q <= native ? load_val : {PAGE_W'(PAGE), load_val[LO_W-1:0]};
        end else if (dec) begin
            if (native)
                sp_q <= sp_q - AW'(1);
            else
                sp_q <= {PAGE_W'(PAGE), sp_q[LO_W-1:0] - LO_W'(1)};
        end
    end

    assign sp = sp_q;

    // R2
    native_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && native) |=> (sp == $past(sp) - AW'(1)));

    // R3
    page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !native) |=>
            (sp[AW-1:LO_W] == PAGE_W'(PAGE) &&
             sp[LO_W-1:0] == $past(sp[LO_W-1:0]) - LO_W'(1)));

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_seq_pkg::*;
#(
    parameter int          INIT_CYCLES = 6,
    parameter logic [7:0]  STACK_PAGE  = 8'h01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2:0]           cause,
    input  logic                 native,
    input  logic                 clr_decimal,
    input  logic [PC_W-1:0]      pc_in,
    input  logic [BANK_W-1:0]    bank_in,
    input  logic [DATA_W-1:0]    status_in,
    input  logic [PC_W-1:0]      sp_in,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 busy,
    output logic                 done,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic [PC_W-1:0]      pc_out,
    output logic [BANK_W-1:0]    bank_out,
    output logic [DATA_W-1:0]    status_out,
    output logic [PC_W-1:0]      sp_out
);

    localparam int CNT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

    state_e               state_q, state_d;
    logic [CNT_W-1:0]     init_q;

    cause_e               cause_q;
    logic                 native_q, clr_q;
    logic [PC_W-1:0]      pc_cap_q;
    logic [BANK_W-1:0]    bank_cap_q;
    logic [DATA_W-1:0]    stat_cap_q;
    logic [DATA_W-1:0]    vec_lo_q;

    logic [PC_W-1:0]      pc_q;
    logic [BANK_W-1:0]    bank_q;
    logic [DATA_W-1:0]    stat_q;

    logic                 accept;
    logic                 pushing;
    logic [PC_W-1:0]      sp_cur;
    logic [PC_W-1:0]      vec;
    logic [PC_W-1:0]      ret_pc;
    logic [DATA_W-1:0]    push_stat;
    logic [DATA_W-1:0]    entry_stat;

    assign accept = (state_q == S_IDLE) && start;

    // ---------------------------------------------------------------
    // submodules
    // ---------------------------------------------------------------
    intr_vec_map #(.AW(PC_W)) u_vec (
        .cause  (cause_q),
        .native (native_q),
        .vec    (vec)
    );

    intr_frame_build u_frame (
        .cause      (cause_q),
        .native     (native_q),
        .clr_dec    (clr_q),
        .pc         (pc_cap_q),
        .status     (stat_cap_q),
        .ret_pc     (ret_pc),
        .push_stat  (push_stat),
        .entry_stat (entry_stat)
    );

    intr_stack_ptr #(
        .AW     (PC_W),
        .PAGE_W (8),
        .PAGE   (STACK_PAGE)
    ) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (sp_in),
        .native   (accept ? native : native_q),
        .dec      (pushing),
        .sp       (sp_cur)
    );

    // ---------------------------------------------------------------
    // state register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            init_q  <= '0;
        end else begin
            state_q <= state_d;
            init_q  <= (state_q == S_INIT) ? init_q + CNT_W'(1) : '0;
        end
    end

    // ---------------------------------------------------------------
    // next state
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (cause_e'(cause) == C_RESET) state_d = S_INIT;
                    else if (native)                state_d = S_PUSH_BANK;
                    else                            state_d = S_PUSH_PCH;
                end
            end
            S_INIT:      state_d = (init_q == CNT_LAST) ? S_VEC_LO : S_INIT;
            S_PUSH_BANK: state_d = S_PUSH_PCH;
            S_PUSH_PCH:  state_d = S_PUSH_PCL;
            S_PUSH_PCL:  state_d = S_PUSH_STAT;
            S_PUSH_STAT: state_d = S_VEC_LO;
            S_VEC_LO:    state_d = S_VEC_HI;
            S_VEC_HI:    state_d = S_DONE;
            S_DONE:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // outputs of the state machine
    // ---------------------------------------------------------------
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        pushing   = 1'b0;
        unique case (state_q)
            S_PUSH_BANK, S_PUSH_PCH, S_PUSH_PCL, S_PUSH_STAT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                pushing  = 1'b1;
                mem_addr = {BANK_W'(0), sp_cur};
                if (state_q == S_PUSH_BANK)     mem_wdata = bank_cap_q;
                else if (state_q == S_PUSH_PCH) mem_wdata = ret_pc[PC_W-1:DATA_W];
                else if (state_q == S_PUSH_PCL) mem_wdata = ret_pc[DATA_W-1:0];
                else                            mem_wdata = push_stat;
            end
            S_VEC_LO: begin
                mem_req  = 1'b1;
                mem_addr = {BANK_W'(0), vec[PC_W-1:1], 1'b0};
            end
            S_VEC_HI: begin
                mem_req  = 1'b1;
                mem_addr = {BANK_W'(0), vec[PC_W-1:1], 1'b1};
            end
            default: ;
        endcase
    end

    assign busy = (state_q != S_IDLE);
    assign done = (state_q == S_DONE);

    // ---------------------------------------------------------------
    // captured context and results
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q    <= C_IRQ;
            native_q   <= 1'b0;
            clr_q      <= 1'b0;
            pc_cap_q   <= '0;
            bank_cap_q <= '0;
            stat_cap_q <= '0;
            vec_lo_q   <= '0;
            pc_q       <= '0;
            bank_q     <= '0;
            stat_q     <= '0;
        end else begin
            if (accept) begin
                cause_q    <= cause_e'(cause);
                native_q   <= native;
                clr_q      <= clr_decimal;
                pc_cap_q   <= pc_in;
                bank_cap_q <= bank_in;
                stat_cap_q <= status_in;
            end
            if (state_q == S_VEC_LO) begin
                vec_lo_q <= mem_rdata;
            end
            if (state_q == S_VEC_HI) begin
                pc_q   <= {mem_rdata, vec_lo_q};
                stat_q <= entry_stat;
                bank_q <= (native_q || cause_q == C_RESET) ? '0 : bank_cap_q;
            end
        end
    end

    assign pc_out     = pc_q;
    assign bank_out   = bank_q;
    assign status_out = stat_q;
    assign sp_out     = sp_cur;

    // ---------------------------------------------------------------
    // assertions
    // ---------------------------------------------------------------
    // R1
    hold_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(cause_q) && $stable(pc_cap_q));

    // R11
    reset_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cause_q == C_RESET) |-> !mem_we);

    // R10
    vec_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && $past(!mem_req || mem_we)) |->
            (mem_addr[0] == 1'b0 && mem_addr[ADDR_W-1:PC_W] == '0));

    // R6
    idis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status_out[FLAG_I]);

    // R7
    bank_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && native_q) |-> (bank_out == '0));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

// File: tb/intr_entry_seq_test.sv
module intr_entry_seq_test;
    import intr_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [2:0]  cause;
    logic        native, clr_decimal;
    logic [15:0] pc_in, sp_in;
    logic [7:0]  bank_in, status_in, mem_rdata;
    logic        busy, done, mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata, bank_out, status_out;
    logic [15:0] pc_out, sp_out;

    always #10 clk = ~clk;

    intr_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cause(cause),
        .native(native), .clr_decimal(clr_decimal), .pc_in(pc_in),
        .bank_in(bank_in), .status_in(status_in), .sp_in(sp_in),
        .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .pc_out(pc_out), .bank_out(bank_out),
        .status_out(status_out), .sp_out(sp_out)
    );

    // memory model: read data is a function of the address
    function automatic logic [7:0] rdv(input logic [15:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction
    assign mem_rdata = rdv(mem_addr[15:0]);

    int n_tests = 0;
    int n_fail  = 0;

    logic [23:0] wr_addr [0:15];
    logic [7:0]  wr_data [0:15];
    logic [23:0] rd_addr [0:7];
    int          wr_n = 0;
    int          rd_n = 0;

    always @(posedge clk) begin
        if (rst_n && mem_req) begin
            if (mem_we) begin
                if (wr_n < 16) begin
                    wr_addr[wr_n] = mem_addr;
                    wr_data[wr_n] = mem_wdata;
                end
                wr_n = wr_n + 1;
            end else begin
                if (rd_n < 8) rd_addr[rd_n] = mem_addr;
                rd_n = rd_n + 1;
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_vec(input logic [2:0] c, input logic nat);
        if (c == 3'd5) return 16'hFFFC;                 // R11
        if (nat) begin                                   // R9
            case (c)
                3'd4: return 16'hFFE8;
                3'd3: return 16'hFFE4;
                3'd2: return 16'hFFE6;
                3'd1: return 16'hFFEA;
                default: return 16'hFFEE;
            endcase
        end
        case (c)                                         // R8
            3'd4: return 16'hFFF8;
            3'd3: return 16'hFFF4;
            3'd1: return 16'hFFFA;
            default: return 16'hFFFE;
        endcase
    endfunction

    task automatic run_case(input logic [2:0] c, input logic nat, input logic clr,
                            input logic [15:0] pc, input logic [7:0] bk,
                            input logic [7:0] st, input logic [15:0] sp,
                            input bit poke);
        int lat;
        logic [15:0] rpc, vec, esp, eaddr;
        logic [7:0]  pst, est, ebk;
        int          nw, elat;

        @(negedge clk);
        cause = c; native = nat; clr_decimal = clr; pc_in = pc;
        bank_in = bk; status_in = st; sp_in = sp;
        wr_n = 0; rd_n = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 3) begin
                start = 1'b1; cause = 3'd1; native = ~nat; clr_decimal = ~clr;
                pc_in = 16'h5555; bank_in = 8'hEE; status_in = 8'hAA; sp_in = 16'h0777;
            end else begin
                start = 1'b0;
            end
        end

        // expectations from the requirements
        rpc  = (c == 3'd2 || c == 3'd3) ? pc + 16'd2 : pc;                  // R4
        pst  = st;
        if (!nat) pst[4] = (c == 3'd2);                                      // R5
        est  = st | 8'h04;                                                   // R6
        if (clr) est = est & 8'hF7;
        ebk  = (nat || c == 3'd5) ? 8'h00 : bk;                              // R7
        vec  = exp_vec(c, nat);
        nw   = (c == 3'd5) ? 0 : (nat ? 4 : 3);
        elat = (c == 3'd5) ? 9 : (nat ? 7 : 6);
        if (nat) esp = sp - 16'(nw);
        else     esp = {8'h01, sp[7:0] - 8'(nw)};

        chk("R12", "latency", lat, elat);
        if (c == 3'd5) begin
            chk("R11", "write count", wr_n, 0);
            chk("R11", "request count", rd_n, 2);
        end else if (nat) begin
            chk("R2", "write count", wr_n, nw);
        end else begin
            chk("R3", "write count", wr_n, nw);
        end
        if (wr_n == nw) begin
            for (int k = 0; k < nw; k++) begin
                if (nat) eaddr = sp - 16'(k);
                else     eaddr = {8'h01, sp[7:0] - 8'(k)};
                chk(nat ? "R2" : "R3", "push addr", wr_addr[k], {8'h00, eaddr});
            end
            if (nat && nw == 4) begin
                chk("R2", "push bank", wr_data[0], bk);
                chk("R4", "push pch", wr_data[1], rpc[15:8]);
                chk("R4", "push pcl", wr_data[2], rpc[7:0]);
                chk("R5", "push status", wr_data[3], pst);
            end else if (nw == 3) begin
                chk("R4", "push pch", wr_data[0], rpc[15:8]);
                chk("R4", "push pcl", wr_data[1], rpc[7:0]);
                chk("R5", "push status", wr_data[2], pst);
            end
        end
        chk("R10", "read count", rd_n, 2);
        if (rd_n == 2) begin
            chk(nat ? "R9" : "R8", "vector lo addr", rd_addr[0], {8'h00, vec});
            chk("R10", "vector hi addr", rd_addr[1], {8'h00, vec | 16'h0001});
        end
        chk("R10", "pc_out", pc_out, {rdv(vec | 16'h0001), rdv(vec)});
        chk("R6", "status_out", status_out, est);
        chk("R7", "bank_out", bank_out, ebk);
        chk(c == 3'd5 ? "R11" : (nat ? "R2" : "R3"), "sp_out", sp_out, esp);
        @(negedge clk);
        chk("R12", "busy after done", busy, 0);
        chk("R12", "done pulse width", done, 0);
    endtask

    // cause, native, clr, pc, bank, status, sp
    localparam logic [52:0] VEC_TAB [0:9] = '{
        {3'd0, 1'b0, 1'b0, 16'h1234, 8'h7F, 8'h38, 16'h00FD},
        {3'd2, 1'b0, 1'b1, 16'h2000, 8'h00, 8'h08, 16'h0080},
        {3'd1, 1'b1, 1'b0, 16'h4321, 8'h12, 8'hC8, 16'h1FF0},
        {3'd2, 1'b1, 1'b1, 16'hABCD, 8'h9A, 8'h0B, 16'h0300},
        {3'd3, 1'b1, 1'b0, 16'hFFFF, 8'h05, 8'h00, 16'h0001},
        {3'd4, 1'b1, 1'b1, 16'h3000, 8'h44, 8'h04, 16'h2000},
        {3'd0, 1'b1, 1'b0, 16'h0800, 8'h21, 8'h10, 16'h0100},
        {3'd3, 1'b0, 1'b1, 16'h0100, 8'h33, 8'h18, 16'h0001},
        {3'd1, 1'b0, 1'b0, 16'h6000, 8'h55, 8'hFF, 16'h01FF},
        {3'd4, 1'b0, 1'b0, 16'h7000, 8'h66, 8'h00, 16'h0100}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R12 watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; cause = 3'd0; native = 1'b0; clr_decimal = 1'b0;
        pc_in = '0; bank_in = '0; status_in = '0; sp_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "done after reset", done, 0);
        chk("R1", "mem_req after reset", mem_req, 0);
        chk("R1", "pc_out after reset", pc_out, 0);

        for (int i = 0; i < 10; i++) begin
            logic [52:0] e;
            e = VEC_TAB[i];
            run_case(e[52:50], e[49], e[48], e[47:32], e[31:24], e[23:16], e[15:0], 1'b0);
        end

        // R11 reset sequence in both modes
        run_case(3'd5, 1'b0, 1'b1, 16'h1111, 8'h22, 8'h08, 16'h00C0, 1'b0);
        run_case(3'd5, 1'b1, 1'b0, 16'h9999, 8'h77, 8'h08, 16'h4000, 1'b0);

        // R1 start and input changes while busy are ignored
        run_case(3'd2, 1'b1, 1'b0, 16'hCAFE, 8'h3A, 8'h09, 16'h0150, 1'b1);
        run_case(3'd0, 1'b0, 1'b1, 16'hBEEF, 8'h4B, 8'h2C, 16'h0010, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule